// File: doc/BRIEF.md
# Received Pause Decode and Transmit Hold

This block sits beside a MAC receive path. Upstream logic has already parsed each incoming frame into a destination address, an EtherType, a control opcode and a 16-bit quanta field, and presents them for one cycle with a valid strobe. The block recognises flow-control PAUSE frames and then stops the local transmitter for the requested number of slot times, where one slot time is 512 bit times. The slot time reaches the block as a one-cycle tick from the transmit clocking logic.

A PAUSE is accepted when it is addressed to the reserved 802.3x multicast group. When unicast detection is enabled, a PAUSE addressed to the station's own address is accepted as well. Each accepted frame reloads a hold counter with its quanta, and a quanta of zero cancels any hold at once. If the transmitter is in the middle of a frame when a PAUSE arrives, the hold waits until that frame has ended. Clearing the receive flow-control enable turns off all decoding and drops the hold.

A three-state machine drives the hold. `S_IDLE` means no pause is pending. `S_ARMED` means a pause has been accepted while a frame is still on the wire. `S_HOLD` means the transmitter is held. The transitions are:

- IDLE→HOLD on a nonzero PAUSE with the transmitter idle.
- IDLE→ARMED on a nonzero PAUSE during a frame.
- ARMED→HOLD when the frame ends.
- ARMED→IDLE or HOLD→IDLE when the count expires, when a zero-quanta PAUSE arrives, or when decoding is disabled.
- HOLD→HOLD on a reload.

Top module: `rx_pause_hold`

## Requirements
- R1: A nonzero PAUSE accepted on the strobe raises `tx_hold` in the cycle after the strobe, with the transmitter idle. `tx_hold` falls in the cycle after the quanta-th `slot_tick` counted from that point.
- R2: While `rx_fc_en` is 0, no frame is accepted and no pulse is produced. `tx_hold` is 0 from the cycle after `rx_fc_en` goes low, and it stays 0 after the enable returns until a new PAUSE arrives.
- R3: A frame is a PAUSE only when all three of these hold: the EtherType is 0x8808, the opcode is 0x0001, and the destination is 0x0180C2000001 (or the station address, see R4). Any other frame leaves `tx_hold` and `pause_rcvd` unchanged.
- R4: A PAUSE addressed to `station_addr` is accepted only while `ucast_det_en` is 1. A PAUSE to an address that is neither the station address nor the multicast address is never accepted.
- R5: A PAUSE accepted during a hold reloads the counter. The hold then ends after the new quanta's worth of ticks, whatever count remained before.
- R6: An accepted PAUSE with a quanta of 0 drops `tx_hold` in the cycle after the strobe.
- R7: A PAUSE accepted while `tx_in_frame` is 1 does not raise `tx_hold` until the cycle after `tx_in_frame` returns to 0. The slot ticks in between still count down the hold.
- R8: `pause_rcvd` is high for exactly the one cycle after the strobe of each accepted PAUSE, including zero-quanta ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_valid | input | 1 | One-cycle strobe for the parsed frame fields |
| frm_dst | input | 48 | Destination address of the frame |
| frm_etype | input | 16 | EtherType / length field |
| frm_opcode | input | 16 | MAC control opcode |
| frm_quanta | input | QW | Requested pause in slot times |
| station_addr | input | 48 | Station's own unicast address |
| rx_fc_en | input | 1 | Enables PAUSE decoding and the transmit hold |
| ucast_det_en | input | 1 | Also accept PAUSE frames addressed to `station_addr` |
| slot_tick | input | 1 | One-cycle pulse per elapsed slot time |
| tx_in_frame | input | 1 | Transmitter is currently sending a frame |
| tx_hold | output | 1 | Transmitter must not start a new frame |
| pause_rcvd | output | 1 | One-cycle pulse per accepted PAUSE |

## Verification
If the hold counter were wrong, the fault would show at the ports only when the count expires. A hold would then end one or more ticks early or late, so each case checks `tx_hold` just before and just after the final tick. If the state register were corrupted, `tx_hold` would be wrong within one cycle of the strobe, the end of the frame or the change of the enable, and each of these moments is sampled in the cycle that follows it. Classification faults show as a missing or extra `pause_rcvd` pulse in the cycle after the strobe, which the scoreboard compares cycle by cycle.

// File: rtl/pause_pkg.sv
package pause_pkg;
    localparam int ADDR_W = 48;
    localparam int TYPE_W = 16;
    localparam logic [ADDR_W-1:0] CTRL_MCAST = 48'h0180C2000001;
    localparam logic [TYPE_W-1:0] ETYPE_MAC_CTRL = 16'h8808;
    localparam logic [TYPE_W-1:0] OPCODE_PAUSE = 16'h0001;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_ARMED = 2'd1,
        S_HOLD  = 2'd2
    } hold_state_t;
endpackage

// File: rtl/pause_classify.sv
module pause_classify
    import pause_pkg::*;
(
    input  logic              frm_valid,
    input  logic [ADDR_W-1:0] frm_dst,
    input  logic [TYPE_W-1:0] frm_etype,
    input  logic [TYPE_W-1:0] frm_opcode,
    input  logic [ADDR_W-1:0] station_addr,
    input  logic              rx_fc_en,
    input  logic              ucast_det_en,
    output logic              accept
);
    logic to_mcast;
    logic to_self;
    logic is_pause;

    always_comb begin
        to_mcast = (frm_dst == CTRL_MCAST);
        to_self  = ucast_det_en && (frm_dst == station_addr);
        is_pause = (frm_etype == ETYPE_MAC_CTRL) && (frm_opcode == OPCODE_PAUSE);
        accept   = frm_valid && rx_fc_en && is_pause && (to_mcast || to_self);
    end
endmodule

// File: rtl/pause_timer.sv
module pause_timer #(
    parameter int QW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          load,
    input  logic [QW-1:0] load_val,
    input  logic          tick,
    output logic          expire
);
    localparam logic [QW-1:0] ONE = QW'(1);

    logic [QW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (tick && cnt != '0) begin
            cnt <= cnt - ONE;
        end
    end

    always_comb begin
        expire = !clr && !load && tick && (cnt == ONE);
    end

    // R1
    property count_step_p;
        @(posedge clk) disable iff (!rst_n)
        (!clr && !load && tick && cnt != '0) |=> (cnt == $past(cnt) - ONE);
    endproperty
    count_step_chk: assert property (count_step_p);

    // R5
    property reload_p;
        @(posedge clk) disable iff (!rst_n)
        (!clr && load) |=> (cnt == $past(load_val));
    endproperty
    reload_chk: assert property (reload_p);
endmodule

// File: rtl/pause_hold_fsm.sv
module pause_hold_fsm
    import pause_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rx_fc_en,
    input  logic accept,
    input  logic accept_zero,
    input  logic expire,
    input  logic tx_in_frame,
    output logic tx_hold
);
    hold_state_t state;
    hold_state_t state_nx;

    always_comb begin
        state_nx = state;
        if (!rx_fc_en) begin
            state_nx = S_IDLE;
        end else if (accept) begin
            if (accept_zero) begin
                state_nx = S_IDLE;
            end else if (state == S_HOLD || !tx_in_frame) begin
                state_nx = S_HOLD;
            end else begin
                state_nx = S_ARMED;
            end
        end else begin
            unique case (state)
                S_IDLE:  state_nx = S_IDLE;
                S_ARMED: begin
                    if (expire) begin
                        state_nx = S_IDLE;
                    end else if (!tx_in_frame) begin
                        state_nx = S_HOLD;
                    end
                end
                S_HOLD:  if (expire) state_nx = S_IDLE;
                default: state_nx = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        tx_hold = (state == S_HOLD);
    end

    // R7
    property enter_between_frames_p;
        @(posedge clk) disable iff (!rst_n)
        $rose(tx_hold) |-> !$past(tx_in_frame);
    endproperty
    enter_between_frames_chk: assert property (enter_between_frames_p);

    // R6
    property zero_release_p;
        @(posedge clk) disable iff (!rst_n)
        (accept && accept_zero) |=> !tx_hold;
    endproperty
    zero_release_chk: assert property (zero_release_p);
endmodule

// File: rtl/rx_pause_hold.sv
module rx_pause_hold
    import pause_pkg::*;
#(
    parameter int QW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frm_valid,
    input  logic [ADDR_W-1:0] frm_dst,
    input  logic [TYPE_W-1:0] frm_etype,
    input  logic [TYPE_W-1:0] frm_opcode,
    input  logic [QW-1:0]     frm_quanta,
    input  logic [ADDR_W-1:0] station_addr,
    input  logic              rx_fc_en,
    input  logic              ucast_det_en,
    input  logic              slot_tick,
    input  logic              tx_in_frame,
    output logic              tx_hold,
    output logic              pause_rcvd
);
    logic accept;
    logic accept_zero;
    logic expire;

    pause_classify u_classify (
        .frm_valid    (frm_valid),
        .frm_dst      (frm_dst),
        .frm_etype    (frm_etype),
        .frm_opcode   (frm_opcode),
        .station_addr (station_addr),
        .rx_fc_en     (rx_fc_en),
        .ucast_det_en (ucast_det_en),
        .accept       (accept)
    );

    always_comb begin
        accept_zero = (frm_quanta == '0);
    end

    pause_timer #(.QW(QW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (!rx_fc_en),
        .load     (accept),
        .load_val (frm_quanta),
        .tick     (slot_tick),
        .expire   (expire)
    );

    pause_hold_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_fc_en    (rx_fc_en),
        .accept      (accept),
        .accept_zero (accept_zero),
        .expire      (expire),
        .tx_in_frame (tx_in_frame),
        .tx_hold     (tx_hold)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pause_rcvd <= 1'b0;
        end else begin
            pause_rcvd <= accept;
        end
    end

    // R8
    property pulse_source_p;
        @(posedge clk) disable iff (!rst_n)
        pause_rcvd |-> $past(frm_valid && rx_fc_en);
    endproperty
    pulse_source_chk: assert property (pulse_source_p);

    // R2
    property disabled_no_hold_p;
        @(posedge clk) disable iff (!rst_n)
        !$past(rx_fc_en) |-> (!tx_hold && !pause_rcvd);
    endproperty
    disabled_no_hold_chk: assert property (disabled_no_hold_p);

    // R4
    property ucast_gate_p;
        @(posedge clk) disable iff (!rst_n)
        (frm_valid && !ucast_det_en && frm_dst != CTRL_MCAST) |=> !pause_rcvd;
    endproperty
    ucast_gate_chk: assert property (ucast_gate_p);
endmodule

// File: tb/sim_rx_pause_hold.sv
module sim_rx_pause_hold;
    localparam logic [47:0] MC   = 48'h0180C2000001;
    localparam logic [47:0] SELF = 48'h02AABBCCDDEE;
    localparam logic [47:0] OTHR = 48'h021122334455;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frm_valid = 1'b0;
    logic [47:0] frm_dst = '0;
    logic [15:0] frm_etype = '0;
    logic [15:0] frm_opcode = '0;
    logic [15:0] frm_quanta = '0;
    logic        rx_fc_en = 1'b1;
    logic        ucast_det_en = 1'b0;
    logic        slot_tick = 1'b0;
    logic        tx_in_frame = 1'b0;
    logic        tx_hold;
    logic        pause_rcvd;

    int n_run = 0;
    int n_fail = 0;
    int cyc = 0;
    int exp_q[$];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    rx_pause_hold u0 (
        .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_dst(frm_dst),
        .frm_etype(frm_etype), .frm_opcode(frm_opcode), .frm_quanta(frm_quanta),
        .station_addr(SELF), .rx_fc_en(rx_fc_en), .ucast_det_en(ucast_det_en),
        .slot_tick(slot_tick), .tx_in_frame(tx_in_frame),
        .tx_hold(tx_hold), .pause_rcvd(pause_rcvd)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic hold_is(input bit e, input string req);
        check(tx_hold == e, req, int'(tx_hold), int'(e));
    endtask

    // driver: starts and ends on a falling edge; pushes the expected pulse cycle
    task automatic send(input logic [47:0] d, input logic [15:0] et, input logic [15:0] op,
                        input logic [15:0] q, input bit expect_acc);
        frm_valid = 1'b1; frm_dst = d; frm_etype = et; frm_opcode = op; frm_quanta = q;
        if (expect_acc) exp_q.push_back(cyc + 1);
        @(negedge clk);
        frm_valid = 1'b0;
    endtask

    task automatic tick();
        slot_tick = 1'b1;
        @(negedge clk);
        slot_tick = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    // monitor: compares each pulse against the scoreboard queue (R8)
    always @(negedge clk) begin
        if (rst_n) begin
            if (pause_rcvd) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8 unexpected pulse", 1, 0);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    check(e == cyc, "R8 pulse cycle", cyc, e);
                end
            end else if (exp_q.size() != 0 && exp_q[0] < cyc) begin
                int e;
                e = exp_q.pop_front();
                check(1'b0, "R8 missing pulse", cyc, e);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        summary();
    end

    initial begin
        idle(2);
        check(!tx_hold && !pause_rcvd, "reset state", int'(tx_hold), 0);
        rst_n = 1'b1;
        idle(2);

        // R1 / R3: multicast PAUSE, quanta 3
        send(MC, 16'h8808, 16'h0001, 16'd3, 1'b1);
        hold_is(1'b1, "R1 hold raised");
        tick(); tick();
        hold_is(1'b1, "R1 hold before last tick");
        tick();
        hold_is(1'b0, "R1 hold released after 3 ticks");

        // R3: wrong EtherType or opcode ignored
        send(MC, 16'h0800, 16'h0001, 16'd5, 1'b0);
        hold_is(1'b0, "R3 wrong ethertype");
        send(MC, 16'h8808, 16'h0002, 16'd5, 1'b0);
        hold_is(1'b0, "R3 wrong opcode");

        // R4: unicast gated by enable
        send(SELF, 16'h8808, 16'h0001, 16'd2, 1'b0);
        hold_is(1'b0, "R4 unicast with detect off");
        ucast_det_en = 1'b1;
        send(OTHR, 16'h8808, 16'h0001, 16'd2, 1'b0);
        hold_is(1'b0, "R4 foreign address");
        send(SELF, 16'h8808, 16'h0001, 16'd2, 1'b1);
        hold_is(1'b1, "R4 unicast with detect on");
        tick(); tick();
        hold_is(1'b0, "R4 unicast hold ends");
        ucast_det_en = 1'b0;

        // R5: reload during hold
        send(MC, 16'h8808, 16'h0001, 16'd5, 1'b1);
        tick(); tick();
        send(MC, 16'h8808, 16'h0001, 16'd2, 1'b1);
        hold_is(1'b1, "R5 hold after reload");
        tick();
        hold_is(1'b1, "R5 one tick after reload");
        tick();
        hold_is(1'b0, "R5 released at new quanta");

        // R6: zero quanta releases at once
        send(MC, 16'h8808, 16'h0001, 16'd9, 1'b1);
        hold_is(1'b1, "R6 hold before zero");
        send(MC, 16'h8808, 16'h0001, 16'd0, 1'b1);
        hold_is(1'b0, "R6 zero quanta release");

        // R7: deferred while a frame is on the wire
        tx_in_frame = 1'b1;
        send(MC, 16'h8808, 16'h0001, 16'd4, 1'b1);
        hold_is(1'b0, "R7 no hold mid-frame");
        tick();
        hold_is(1'b0, "R7 still mid-frame");
        tx_in_frame = 1'b0;
        idle(1);
        hold_is(1'b1, "R7 hold after frame end");
        tick(); tick();
        hold_is(1'b1, "R7 remaining count");
        tick();
        hold_is(1'b0, "R7 released after total 4 ticks");

        // R2: disable drops hold and blocks decoding
        send(MC, 16'h8808, 16'h0001, 16'd10, 1'b1);
        hold_is(1'b1, "R2 hold before disable");
        rx_fc_en = 1'b0;
        idle(1);
        hold_is(1'b0, "R2 hold dropped on disable");
        send(MC, 16'h8808, 16'h0001, 16'd10, 1'b0);
        hold_is(1'b0, "R2 no hold while disabled");
        rx_fc_en = 1'b1;
        idle(2);
        hold_is(1'b0, "R2 no hold after re-enable");

        idle(3);
        check(exp_q.size() == 0, "R8 all pulses seen", exp_q.size(), 0);
        summary();
    end
endmodule